// File: doc/BRIEF.md
# Flash Protection Status Register Block

This block is the byte-wide protection and status register pair of a flash and data-memory controller. It has two registers. The first is a write-only unlock key register. Two consecutive correct key bytes written to it open the data area for writing. The second is a status register. It gathers flags that the controller hardware raises: a program area unlock, a data area unlock, end of programming, a write attempt to a protected page, and the high-voltage state.

The flags do not all clear in the same way. The two unlock flags stay set until software writes a zero to their bit. Writing a one to them does nothing. The end-of-programming flag clears when software reads the status register or when a new write or erase begins. The protected-page flag clears only on a status read. The high-voltage bit follows the hardware alone. When a hardware set and a software clear land in the same cycle, the set wins. A clear-on-read takes effect one cycle after the read strobe, so the read itself still returns the flag as set. An interrupt output combines the two event flags and is gated by an enable input.

The data-area key check is a two-state machine. In `KS_WAIT_FIRST` it waits for the first key byte. A write of 0xAE to the key register moves it to `KS_WAIT_SECOND`, and any other value keeps it where it is. In `KS_WAIT_SECOND`, a write of 0x56 raises the unlock and returns the machine to `KS_WAIT_FIRST`. Any other value written to the key register, 0xAE included, also returns it to `KS_WAIT_FIRST`, with no unlock. Bus accesses to other addresses do not move the machine.

Top module: `flash_prot_regs`

## Requirements
- R1: After reset, a status read (offset 0x05) returns 0x40, a key register read returns 0x00 and `irq` is 0.
- R2: The key register (offset 0x0A) accepts writes and always reads 0x00.
- R3: Status bits 7, 5 and 4 always read 0, and reads at any offset other than 0x05 return 0x00. `bus_rdata` is 0x00 when `bus_rd` is low.
- R4: Status bit 6 shows the `hv_off` input as sampled at the previous clock edge. A status write never changes it.
- R5: Status bit 3 is set by a key write of 0xAE followed by a key write of 0x56, with no other key write between them. Accesses to other offsets may fall between the two writes. Any other value written in place of the second byte, 0xAE included, cancels the sequence without setting bit 3.
- R6: A status write with bit 3 of the data at 0 clears status bit 3. A status write with bit 3 of the data at 1 leaves it unchanged.
- R7: Status bit 1 is set one cycle after `evt_prog_unlock`. A status write with data bit 1 at 0 clears it, and one with data bit 1 at 1 leaves it unchanged.
- R8: Status bit 2 is set one cycle after `evt_op_done`. It is cleared by a status read or by `evt_op_start`, and status writes do not affect it.
- R9: Status bit 0 is set one cycle after `evt_prot_wr`. It is cleared only by a status read, and status writes do not affect it.
- R10: A status read returns the flags as they stand before the clear. The clear-on-read is visible from the next cycle.
- R11: When a flag's set event and one of its clears occur in the same cycle, the flag is 1 on the next cycle.
- R12: `irq` is high exactly when `irq_en` is high and status bit 2 or bit 0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (4) | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| evt_prog_unlock | input | 1 | Pulse: correct program-area key sequence seen |
| evt_prot_wr | input | 1 | Pulse: write attempted to a protected page |
| evt_op_done | input | 1 | Pulse: write or erase completed |
| evt_op_start | input | 1 | Pulse: new write or erase started |
| hv_off | input | 1 | Level: high voltage is off |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Combined event interrupt |

## Verification
Every internal flag can be seen at the ports through the status byte or through `irq`. A key machine stuck in the wrong state shows up on the first status read after the second key byte, which sets bit 3 when it should not or fails to set it when it should. A clear rule wired to the wrong event shows up in the cycle after that event, when the reference model's status byte and the design's no longer match. An event flag that is wrong changes `irq` in the same cycle whenever `irq_en` is high, with no read needed.

// File: rtl/flash_prot_pkg.sv
package flash_prot_pkg;

    localparam int unsigned DATA_W   = 8;
    localparam int unsigned FLAG_N   = 4;

    // register offsets
    localparam int unsigned OFS_STAT = 5;
    localparam int unsigned OFS_KEY  = 10;

    // data-area key bytes, in the order they must arrive
    localparam logic [DATA_W-1:0] KEY_FIRST  = 8'hAE;
    localparam logic [DATA_W-1:0] KEY_SECOND = 8'h56;

    // status bit positions
    localparam int unsigned BIT_WPD = 0;
    localparam int unsigned BIT_PUL = 1;
    localparam int unsigned BIT_EOP = 2;
    localparam int unsigned BIT_DUL = 3;
    localparam int unsigned BIT_HV  = 6;

    // per-flag clear rules, bit i of each mask covers flag i
    localparam logic [FLAG_N-1:0] CLR_RD_MASK = 4'b0101;
    localparam logic [FLAG_N-1:0] CLR_WZ_MASK = 4'b1010;
    localparam logic [FLAG_N-1:0] CLR_OP_MASK = 4'b0100;

    typedef enum logic [0:0] {
        KS_WAIT_FIRST  = 1'b0,
        KS_WAIT_SECOND = 1'b1
    } key_state_t;

endpackage

// File: rtl/flash_key_seq.sv
module flash_key_seq
    import flash_prot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr_i,
    input  logic [DATA_W-1:0] key_data_i,
    output logic              unlock_o
);

    key_state_t state_q;
    key_state_t state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KS_WAIT_FIRST: begin
                if (key_wr_i && (key_data_i == KEY_FIRST)) begin
                    state_d = KS_WAIT_SECOND;
                end
            end
            KS_WAIT_SECOND: begin
                // any key write leaves this state, right or wrong
                if (key_wr_i) begin
                    state_d = KS_WAIT_FIRST;
                end
            end
            default: state_d = KS_WAIT_FIRST;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= KS_WAIT_FIRST;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        unlock_o = 1'b0;
        unique case (state_q)
            KS_WAIT_FIRST:  unlock_o = 1'b0;
            KS_WAIT_SECOND: unlock_o = key_wr_i && (key_data_i == KEY_SECOND);
            default:        unlock_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/flash_flag_cell.sv
module flash_flag_cell #(
    parameter bit CLR_ON_RD = 1'b0,
    parameter bit CLR_ON_WZ = 1'b0,
    parameter bit CLR_ON_OP = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_clr_i,
    input  logic wz_clr_i,
    input  logic op_clr_i,
    output logic flag_o
);

    logic clr;

    always_comb begin
        clr = (CLR_ON_RD && rd_clr_i) ||
              (CLR_ON_WZ && wz_clr_i) ||
              (CLR_ON_OP && op_clr_i);
    end

    // a set beats any clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clr) begin
            flag_o <= 1'b0;
        end
    end

endmodule

// File: rtl/flash_prot_regs.sv
module flash_prot_regs
    import flash_prot_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              evt_prog_unlock,
    input  logic              evt_prot_wr,
    input  logic              evt_op_done,
    input  logic              evt_op_start,
    input  logic              hv_off,
    input  logic              irq_en,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(OFS_KEY);

    logic              sel_stat;
    logic              sel_key;
    logic              rd_stat;
    logic              wr_stat;
    logic              wr_key;
    logic              unlock_hit;
    logic [FLAG_N-1:0] flag_set;
    logic [FLAG_N-1:0] flags_q;
    logic              hv_q;
    logic [DATA_W-1:0] stat_byte;

    always_comb begin
        sel_stat = (bus_addr == A_STAT);
        sel_key  = (bus_addr == A_KEY);
        rd_stat  = bus_rd && sel_stat;
        wr_stat  = bus_wr && sel_stat;
        wr_key   = bus_wr && sel_key;
    end

    flash_key_seq u_key (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_wr_i   (wr_key),
        .key_data_i (bus_wdata),
        .unlock_o   (unlock_hit)
    );

    always_comb begin
        flag_set          = '0;
        flag_set[BIT_WPD] = evt_prot_wr;
        flag_set[BIT_PUL] = evt_prog_unlock;
        flag_set[BIT_EOP] = evt_op_done;
        flag_set[BIT_DUL] = unlock_hit;
    end

    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        flash_flag_cell #(
            .CLR_ON_RD (CLR_RD_MASK[i]),
            .CLR_ON_WZ (CLR_WZ_MASK[i]),
            .CLR_ON_OP (CLR_OP_MASK[i])
        ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (flag_set[i]),
            .rd_clr_i (rd_stat),
            .wz_clr_i (wr_stat && !bus_wdata[i]),
            .op_clr_i (evt_op_start),
            .flag_o   (flags_q[i])
        );
    end

    // high-voltage state, hardware only; reset value is "off"
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hv_q <= 1'b1;
        end else begin
            hv_q <= hv_off;
        end
    end

    always_comb begin
        stat_byte                  = '0;
        stat_byte[BIT_HV]          = hv_q;
        stat_byte[FLAG_N-1:0]      = flags_q;
    end

    // key register is write-only and reads as zero
    always_comb begin
        bus_rdata = '0;
        if (rd_stat) begin
            bus_rdata = stat_byte;
        end
    end

    always_comb begin
        irq = irq_en && (flags_q[BIT_EOP] || flags_q[BIT_WPD]);
    end

endmodule

// File: rtl/flash_prot_chk.sv
module flash_prot_chk
    import flash_prot_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              evt_prot_wr,
    input logic              evt_op_done,
    input logic              hv_off,
    input logic              irq_en,
    input logic              irq,
    input logic [FLAG_N-1:0] flags_q,
    input logic              hv_q
);

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(OFS_KEY);

    assert_key_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_KEY) |-> (bus_rdata == '0));

    assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> (bus_rdata[7] == 1'b0 && bus_rdata[5:4] == 2'b00));

    assert_hv_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (hv_q == $past(hv_off)));

    assert_dul_w1_noeffect_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_STAT && bus_wdata[BIT_DUL]) |=>
        (flags_q[BIT_DUL] == $past(flags_q[BIT_DUL])));

    assert_dul_wz_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_STAT && !bus_wdata[BIT_DUL]) |=> !flags_q[BIT_DUL]);

    assert_wpd_rd_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_STAT && !evt_prot_wr) |=> !flags_q[BIT_WPD]);

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        evt_op_done |=> flags_q[BIT_EOP]);

    assert_irq_on_event_R12: assert property (@(posedge clk) disable iff (!rst_n)
        evt_prot_wr |=> (irq || !irq_en));

endmodule

bind flash_prot_regs flash_prot_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .evt_prot_wr (evt_prot_wr),
    .evt_op_done (evt_op_done),
    .hv_off      (hv_off),
    .irq_en      (irq_en),
    .irq         (irq),
    .flags_q     (flags_q),
    .hv_q        (hv_q)
);

// File: tb/flash_prot_regs_tb.sv
module flash_prot_regs_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = 4'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       evt_prog_unlock = 1'b0;
    logic       evt_prot_wr = 1'b0;
    logic       evt_op_done = 1'b0;
    logic       evt_op_start = 1'b0;
    logic       hv_off = 1'b1;
    logic       irq_en = 1'b0;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference model state
    bit m_dul, m_eop, m_pul, m_wpd, m_hv;
    int m_ks;

    always #10 clk = ~clk;

    flash_prot_regs #(.ADDR_W(4)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .bus_addr        (bus_addr),
        .bus_wr          (bus_wr),
        .bus_rd          (bus_rd),
        .bus_wdata       (bus_wdata),
        .bus_rdata       (bus_rdata),
        .evt_prog_unlock (evt_prog_unlock),
        .evt_prot_wr     (evt_prot_wr),
        .evt_op_done     (evt_op_done),
        .evt_op_start    (evt_op_start),
        .hv_off          (hv_off),
        .irq_en          (irq_en),
        .irq             (irq)
    );

    // behavioural model: clears first, sets afterwards so a set wins
    always @(posedge clk) begin
        if (!rst_n) begin
            m_dul = 0; m_eop = 0; m_pul = 0; m_wpd = 0; m_hv = 1; m_ks = 0;
        end else begin
            bit unl;
            unl = 0;
            if (bus_wr && bus_addr == 4'd10) begin
                if (m_ks == 1) begin
                    unl = (bus_wdata == 8'h56);
                    m_ks = 0;
                end else begin
                    m_ks = (bus_wdata == 8'hAE) ? 1 : 0;
                end
            end
            if (bus_rd && bus_addr == 4'd5) begin
                m_eop = 0; m_wpd = 0;
            end
            if (evt_op_start) m_eop = 0;
            if (bus_wr && bus_addr == 4'd5) begin
                if (!bus_wdata[3]) m_dul = 0;
                if (!bus_wdata[1]) m_pul = 0;
            end
            if (unl) m_dul = 1;
            if (evt_op_done) m_eop = 1;
            if (evt_prog_unlock) m_pul = 1;
            if (evt_prot_wr) m_wpd = 1;
            m_hv = hv_off;
        end
    end

    function automatic logic [7:0] exp_rdata();
        if (bus_rd && bus_addr == 4'd5)
            return {1'b0, m_hv, 2'b00, m_dul, m_eop, m_pul, m_wpd};
        return 8'h00;
    endfunction

    task automatic check8(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    // compare with the model in this cycle, then return strobes to idle
    task automatic tick(input string tag);
        #2;
        check8(tag, bus_rdata, exp_rdata());
        check8(tag, {7'd0, irq}, {7'd0, irq_en && (m_eop || m_wpd)});
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; bus_wdata = 0; bus_addr = 0;
        evt_prog_unlock = 0; evt_prot_wr = 0; evt_op_done = 0; evt_op_start = 0;
    endtask

    task automatic wr(input string tag, input logic [3:0] a, input logic [7:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        tick(tag);
    endtask

    task automatic rd(input string tag, input logic [3:0] a, input logic [7:0] exp);
        bus_rd = 1; bus_addr = a;
        #1;
        check8(tag, bus_rdata, exp);
        tick(tag);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        rd("R1", 4'd5, 8'h40);
        rd("R1", 4'd10, 8'h00);
        check8("R1", {7'd0, irq}, 8'h00);
        // R2 key register is write-only
        wr("R2", 4'd10, 8'h33);
        rd("R2", 4'd10, 8'h00);
        // R3 other offsets read zero
        rd("R3", 4'd3, 8'h00);
        rd("R3", 4'd15, 8'h00);
        // R4 high-voltage bit follows input one cycle late
        hv_off = 0;
        rd("R4", 4'd5, 8'h40);
        rd("R4", 4'd5, 8'h00);
        wr("R4", 4'd5, 8'hFF);
        rd("R4", 4'd5, 8'h00);
        hv_off = 1;
        tick("R4");
        // R5 key sequence
        wr("R5", 4'd10, 8'hAE);
        wr("R5", 4'd10, 8'h56);
        rd("R5", 4'd5, 8'h48);
        // R6 write one keeps, write zero clears
        wr("R6", 4'd5, 8'h08);
        rd("R6", 4'd5, 8'h48);
        wr("R6", 4'd5, 8'hF7);
        rd("R6", 4'd5, 8'h40);
        // R5 wrong second byte
        wr("R5", 4'd10, 8'hAE);
        wr("R5", 4'd10, 8'h12);
        wr("R5", 4'd10, 8'h56);
        rd("R5", 4'd5, 8'h40);
        // R5 repeated first byte cancels
        wr("R5", 4'd10, 8'hAE);
        wr("R5", 4'd10, 8'hAE);
        wr("R5", 4'd10, 8'h56);
        rd("R5", 4'd5, 8'h40);
        // R5 other accesses between key bytes
        wr("R5", 4'd10, 8'hAE);
        rd("R5", 4'd5, 8'h40);
        wr("R5", 4'd3, 8'h00);
        wr("R5", 4'd10, 8'h56);
        rd("R5", 4'd5, 8'h48);
        wr("R6", 4'd5, 8'h00);
        // R7 program-area unlock flag
        evt_prog_unlock = 1;
        tick("R7");
        rd("R7", 4'd5, 8'h42);
        wr("R7", 4'd5, 8'h02);
        rd("R7", 4'd5, 8'h42);
        wr("R7", 4'd5, 8'hFD);
        rd("R7", 4'd5, 8'h40);
        // R8 end of programming, R12 interrupt, R10 read-then-clear
        irq_en = 1;
        evt_op_done = 1;
        tick("R8");
        check8("R12", {7'd0, irq}, 8'h01);
        irq_en = 0;
        #1 check8("R12", {7'd0, irq}, 8'h00);
        irq_en = 1;
        wr("R8", 4'd5, 8'h00);
        rd("R10", 4'd5, 8'h44);
        rd("R10", 4'd5, 8'h40);
        check8("R12", {7'd0, irq}, 8'h00);
        evt_op_done = 1;
        tick("R8");
        evt_op_start = 1;
        tick("R8");
        rd("R8", 4'd5, 8'h40);
        // R9 protected-page flag
        evt_prot_wr = 1;
        tick("R9");
        check8("R12", {7'd0, irq}, 8'h01);
        wr("R9", 4'd5, 8'h00);
        rd("R9", 4'd5, 8'h41);
        rd("R9", 4'd5, 8'h40);
        // R11 set wins over clear
        evt_prot_wr = 1; evt_op_done = 1; bus_rd = 1; bus_addr = 4'd5;
        tick("R11");
        rd("R11", 4'd5, 8'h45);
        evt_op_done = 1; evt_op_start = 1;
        tick("R11");
        rd("R11", 4'd5, 8'h44);
        evt_prog_unlock = 1; bus_wr = 1; bus_addr = 4'd5; bus_wdata = 8'h00;
        tick("R11");
        rd("R11", 4'd5, 8'h42);
        repeat (4) tick("R12");
        summary();
    end

endmodule